// File: doc/BRIEF.md
# EEPROM Checksum Shadow Loader

This block keeps a register copy of a 64-word configuration EEPROM so that the rest of the chip can read configuration words in two cycles. It reads the whole image through a word request port that faces the EEPROM command sequencer. It does this once after reset and again whenever it is told to. The image is accepted only when its words add up to a fixed target and the init control word carries a valid signature. After that, the block answers single-word lookups from its shadow copy.

Lookups are made with an index. An index beyond the image, or a lookup that finds the image invalid even after one reload attempt, returns zero. A repair command recomputes the checksum word from the shadow copy and writes it to the last EEPROM location. Because that write changes the EEPROM, the shadow copy stops being trusted until it is loaded again. A read error from the sequencer stops a load and sets a sticky error flag.

Top module: `eeprom_shadow_loader`

## Requirements
- R1: After reset, `cache_valid`, `load_err` and `lk_ack` are 0. The block then loads the image by itself, issuing one read per word at addresses 0, 1, ..., 63 in ascending order.
- R2: A load finishes with `cache_valid` = 1 only when two conditions hold: the 16-bit wraparound sum of words 0 to 63 equals 0xBABA, and bits 15:14 of word 10 (the init control word) equal 2'b01.
- R3: When a load ends with a checksum mismatch, the cached copy of word 10 is replaced by 0x0000. This is visible through the value a later repair writes.
- R4: When the checksum matches but the signature does not, `cache_valid` stays 0 and the cached word 10 keeps the value read from the EEPROM.
- R5: A lookup that finds the cache valid answers with a one-cycle `lk_ack` pulse carrying the stored word, and it causes no EEPROM traffic.
- R6: A lookup with an index of 64 or more answers 0 and starts no reload.
- R7: A lookup with an in-range index that finds the cache invalid first runs one full 64-word reload. It then answers with the word if the reload succeeded, or with 0 if it did not.
- R8: `start_repair` sums shadow words 0 to 62 and writes (0xBABA minus that sum) mod 2^16 to EEPROM address 63. The write is the only request with `mem_we` = 1.
- R9: A repair drops `cache_valid` to 0 and clears the cached word 10, so the next in-range lookup reloads the image.
- R10: A read returned with `mem_err` = 1 ends the load with no further reads. `cache_valid` is left at 0 and `load_err` is set to 1. `load_err` stays at 1 until reset, even across later good loads.
- R11: `start_load` and `start_repair` are ignored while a load or repair is running, and `start_load` wins when both arrive together. A lookup issued during a load waits for that load to finish and does not start a second one.
- R12: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_load | input | 1 | Pulse: reload the whole image |
| start_repair | input | 1 | Pulse: recompute and program the checksum word |
| mem_req | output | 1 | Word request to the sequencer |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 6 | EEPROM word address |
| mem_wdata | output | 16 | Word to write |
| mem_ack | input | 1 | One-cycle completion of the current request |
| mem_rdata | input | 16 | Read word, valid with `mem_ack` |
| mem_err | input | 1 | Request failed, valid with `mem_ack` |
| lk_req | input | 1 | Pulse: lookup request |
| lk_idx | input | 8 | Lookup word index |
| lk_ack | output | 1 | One-cycle lookup answer strobe |
| lk_data | output | 16 | Lookup answer |
| cache_valid | output | 1 | Shadow image accepted |
| load_err | output | 1 | Sticky sequencer error flag |

## Verification
The bench builds the block with its default parameters: 64 words of 16 bits, an 8-bit lookup index, the init control word at index 10 and a target of 0xBABA. The 8-bit index lets lookups reach 64 and 255, so the out-of-range path is exercised next to the last valid word, 63. The 64-word depth means the repair writes the real final address, and a complete reload shows up as exactly 64 reads in the sequencer model. With the default signature position, two bad images can be built: one with a good sum and a bad signature, and one with a bad sum and a good signature. These two cases leave different cached values for word 10, and the repaired checksum word tells them apart.

// File: rtl/esl_pkg.sv
package esl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOAD  = 2'd1,
      ST_SUM   = 2'd2,
      ST_WRITE = 2'd3
   } esl_state_e;
endpackage

// File: rtl/esl_shadow_rf.sv
module esl_shadow_rf #(
   parameter int WORDS   = 64,
   parameter int DW      = 16,
   parameter int ICW_IDX = 10,
   localparam int AW     = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          icw_clr,
   input  logic [AW-1:0] rd_a_addr,
   output logic [DW-1:0] rd_a_data,
   input  logic [AW-1:0] rd_b_addr,
   output logic [DW-1:0] rd_b_data,
   output logic [DW-1:0] icw_word
);
   logic [WORDS*DW-1:0] flat;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (icw_clr && (w == ICW_IDX))
            q <= '0;
         else if (wr_en && (wr_addr == AW'(w)))
            q <= wr_data;
      end
      assign flat[w*DW +: DW] = q;
   end

   assign rd_a_data = flat[rd_a_addr*DW +: DW];
   assign rd_b_data = flat[rd_b_addr*DW +: DW];
   assign icw_word  = flat[ICW_IDX*DW +: DW];
endmodule

// File: rtl/esl_sum_unit.sv
module esl_sum_unit #(
   parameter int             DW     = 16,
   parameter logic [DW-1:0]  TARGET = 16'hBABA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          add_en,
   input  logic [DW-1:0] add_val,
   output logic [DW-1:0] sum_next,
   output logic          hit,
   output logic [DW-1:0] fix
);
   logic [DW-1:0] acc;

   assign sum_next = acc + add_val;
   assign hit      = (sum_next == TARGET);
   assign fix      = TARGET - sum_next;

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc <= '0;
      else if (clr)
         acc <= '0;
      else if (add_en)
         acc <= sum_next;
   end
endmodule

// File: rtl/esl_lookup_q.sv
module esl_lookup_q #(
   parameter int IW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lk_req,
   input  logic [IW-1:0] lk_idx,
   input  logic          serve,
   input  logic          mark_tried,
   output logic          pend,
   output logic [IW-1:0] idx,
   output logic          tried
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend  <= 1'b0;
         idx   <= '0;
         tried <= 1'b0;
      end else if (serve) begin
         pend  <= 1'b0;
         tried <= 1'b0;
      end else if (!pend && lk_req) begin
         pend <= 1'b1;
         idx  <= lk_idx;
      end else if (mark_tried) begin
         tried <= 1'b1;
      end
   end
endmodule

// File: rtl/eeprom_shadow_loader.sv
module eeprom_shadow_loader #(
   parameter int                   WORDS      = 64,
   parameter int                   DW         = 16,
   parameter int                   IW         = 8,
   parameter int                   ICW_IDX    = 10,
   parameter int                   SIG_LSB    = 14,
   parameter int                   SIG_W      = 2,
   parameter logic [SIG_W-1:0]     SIG_OK     = 2'b01,
   parameter logic [DW-1:0]        SUM_TARGET = 16'hBABA,
   parameter bit                   AUTO_LOAD  = 1'b1,
   localparam int                  AW         = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_load,
   input  logic          start_repair,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_err,
   input  logic          lk_req,
   input  logic [IW-1:0] lk_idx,
   output logic          lk_ack,
   output logic [DW-1:0] lk_data,
   output logic          cache_valid,
   output logic          load_err
);
   import esl_pkg::*;

   localparam logic [AW-1:0] LAST   = AW'(WORDS - 1);
   localparam logic [AW-1:0] PENULT = AW'(WORDS - 2);
   localparam logic [IW:0]   LIMIT  = (IW + 1)'(WORDS);

   // elaboration-time parameter checks
   if (WORDS < 4) begin : g_bad_words
      $error("WORDS must be at least 4");
   end
   if (ICW_IDX >= WORDS - 1) begin : g_bad_icw
      $error("ICW_IDX must sit below the checksum word");
   end
   if (SIG_LSB + SIG_W > DW) begin : g_bad_sig
      $error("signature field exceeds word width");
   end
   if (IW < AW) begin : g_bad_iw
      $error("IW must cover the word address");
   end

   esl_state_e    state;
   logic [AW-1:0] cnt;
   logic          boot_pend;
   logic          valid_q, err_q;
   logic          req_q, we_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic          ack_q;
   logic [DW-1:0] data_q;

   logic          pend, tried;
   logic [IW-1:0] pidx;
   logic          in_range, need_serve, need_reload;
   logic          serve, start_ld, start_rp, mark_tried;

   logic          rd_ok, wr_done, last_rd;
   logic          rf_we;
   logic [DW-1:0] rf_wdata;
   logic          icw_clr;
   logic [DW-1:0] rd_a_data, rd_b_data, icw_word;
   logic          sig_ok;

   logic          sum_clr, sum_add;
   logic [DW-1:0] sum_val, sum_next, sum_fix;
   logic          sum_hit;

   // lookup bookkeeping and arbitration in IDLE
   assign in_range    = ({1'b0, pidx} < LIMIT);
   assign need_serve  = pend && (!in_range || valid_q || tried);
   assign need_reload = pend && in_range && !valid_q && !tried;
   assign serve       = (state == ST_IDLE) && need_serve;
   assign start_ld    = (state == ST_IDLE) && !need_serve &&
                        (need_reload || boot_pend || start_load);
   assign start_rp    = (state == ST_IDLE) && !need_serve && !start_ld && start_repair;
   assign mark_tried  = start_ld && pend;

   // shadow write path
   assign rd_ok    = (state == ST_LOAD) && mem_ack && !mem_err;
   assign last_rd  = rd_ok && (cnt == LAST);
   assign wr_done  = (state == ST_WRITE) && mem_ack;
   assign rf_we    = rd_ok || (wr_done && !mem_err);
   assign rf_wdata = we_q ? wdata_q : mem_rdata;
   assign icw_clr  = (last_rd && !sum_hit) || wr_done;
   assign sig_ok   = (icw_word[SIG_LSB +: SIG_W] == SIG_OK);

   // running sum feed
   assign sum_clr = start_ld || start_rp;
   assign sum_add = rd_ok || (state == ST_SUM);
   assign sum_val = (state == ST_LOAD) ? mem_rdata : rd_b_data;

   esl_shadow_rf #(.WORDS(WORDS), .DW(DW), .ICW_IDX(ICW_IDX)) u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (rf_we),
      .wr_addr   (addr_q),
      .wr_data   (rf_wdata),
      .icw_clr   (icw_clr),
      .rd_a_addr (pidx[AW-1:0]),
      .rd_a_data (rd_a_data),
      .rd_b_addr (cnt),
      .rd_b_data (rd_b_data),
      .icw_word  (icw_word)
   );

   esl_sum_unit #(.DW(DW), .TARGET(SUM_TARGET)) u_sum (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (sum_clr),
      .add_en   (sum_add),
      .add_val  (sum_val),
      .sum_next (sum_next),
      .hit      (sum_hit),
      .fix      (sum_fix)
   );

   esl_lookup_q #(.IW(IW)) u_lq (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_req     (lk_req),
      .lk_idx     (lk_idx),
      .serve      (serve),
      .mark_tried (mark_tried),
      .pend       (pend),
      .idx        (pidx),
      .tried      (tried)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         boot_pend <= AUTO_LOAD;
         valid_q   <= 1'b0;
         err_q     <= 1'b0;
         req_q     <= 1'b0;
         we_q      <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
         ack_q     <= 1'b0;
         data_q    <= '0;
      end else begin
         ack_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (serve) begin
                  ack_q  <= 1'b1;
                  data_q <= (in_range && valid_q) ? rd_a_data : '0;
               end else if (start_ld) begin
                  state     <= ST_LOAD;
                  cnt       <= '0;
                  boot_pend <= 1'b0;
                  valid_q   <= 1'b0;
                  req_q     <= 1'b1;
                  we_q      <= 1'b0;
                  addr_q    <= '0;
               end else if (start_rp) begin
                  state   <= ST_SUM;
                  cnt     <= '0;
                  valid_q <= 1'b0;
               end
            end
            ST_LOAD: begin
               if (mem_ack) begin
                  if (mem_err) begin
                     err_q <= 1'b1;
                     req_q <= 1'b0;
                     state <= ST_IDLE;
                  end else if (cnt == LAST) begin
                     req_q   <= 1'b0;
                     state   <= ST_IDLE;
                     valid_q <= sum_hit && sig_ok;
                  end else begin
                     cnt    <= cnt + 1'b1;
                     addr_q <= cnt + 1'b1;
                  end
               end
            end
            ST_SUM: begin
               if (cnt == PENULT) begin
                  state   <= ST_WRITE;
                  req_q   <= 1'b1;
                  we_q    <= 1'b1;
                  addr_q  <= LAST;
                  wdata_q <= sum_fix;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_WRITE: begin
               if (mem_ack) begin
                  req_q <= 1'b0;
                  we_q  <= 1'b0;
                  state <= ST_IDLE;
                  if (mem_err) err_q <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_req     = req_q;
   assign mem_we      = we_q;
   assign mem_addr    = addr_q;
   assign mem_wdata   = wdata_q;
   assign lk_ack      = ack_q;
   assign lk_data     = data_q;
   assign cache_valid = valid_q;
   assign load_err    = err_q;
endmodule

// File: rtl/esl_checker.sv
module esl_checker #(
   parameter int WORDS = 64,
   parameter int DW    = 16,
   localparam int AW   = $clog2(WORDS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic          mem_ack,
   input logic          lk_ack,
   input logic [DW-1:0] lk_data,
   input logic          cache_valid,
   input logic          load_err
);
   localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R12
   AST_WRITE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_addr == LAST); // R8
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      lk_ack |=> !lk_ack); // R5
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      lk_ack && !cache_valid |-> lk_data == '0); // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |=> load_err); // R10
   AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cache_valid |-> !mem_req); // R9
   AST_VALID_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cache_valid) |-> $past(mem_ack) && !$past(mem_we)); // R2
endmodule

bind eeprom_shadow_loader esl_checker #(.WORDS(WORDS), .DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_req     (mem_req),
   .mem_we      (mem_we),
   .mem_addr    (mem_addr),
   .mem_wdata   (mem_wdata),
   .mem_ack     (mem_ack),
   .lk_ack      (lk_ack),
   .lk_data     (lk_data),
   .cache_valid (cache_valid),
   .load_err    (load_err)
);

// File: tb/tb_eeprom_shadow_loader.sv
`timescale 1ns/1ps
module tb_eeprom_shadow_loader;
   localparam int WORDS = 64;
   localparam int DW    = 16;
   localparam int IW    = 8;
   localparam int AW    = 6;
   localparam logic [15:0] TGT = 16'hBABA;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_load = 1'b0, start_repair = 1'b0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_ack = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_err = 1'b0;
   logic          lk_req = 1'b0;
   logic [IW-1:0] lk_idx = '0;
   logic          lk_ack;
   logic [DW-1:0] lk_data;
   logic          cache_valid, load_err;

   int n_chk = 0, n_fail = 0;
   int n_reads = 0, n_writes = 0, order_bad = 0, hold_bad = 0;
   int err_at = -1;
   int next_rd = 0;
   bit done = 0;
   logic [15:0] last_wdata = '0;
   logic [15:0] ee [WORDS];

   always #5 clk = ~clk;

   eeprom_shadow_loader dut (
      .clk(clk), .rst_n(rst_n), .start_load(start_load), .start_repair(start_repair),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
      .lk_req(lk_req), .lk_idx(lk_idx), .lk_ack(lk_ack), .lk_data(lk_data),
      .cache_valid(cache_valid), .load_err(load_err)
   );

   // sequencer model: one idle cycle of latency, then a one-cycle ack
   initial begin
      int lat = 0;
      logic [AW-1:0] held = '0;
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
         end else if (rst_n && mem_req) begin
            if (lat == 0) begin
               held = mem_addr;
               lat  = 1;
            end else begin
               if (mem_addr !== held) hold_bad++;
               lat = 0;
               mem_ack = 1'b1;
               if (mem_we) begin
                  ee[mem_addr] = mem_wdata;
                  last_wdata   = mem_wdata;
                  n_writes++;
               end else begin
                  if (mem_addr == 0) next_rd = 0;
                  if (int'(mem_addr) != next_rd) order_bad++;
                  next_rd++;
                  mem_rdata = ee[mem_addr];
                  mem_err   = (err_at == int'(mem_addr));
                  n_reads++;
               end
            end
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] sum_upto(input int n);
      logic [15:0] s = '0;
      for (int i = 0; i < n; i++) s = s + ee[i];
      return s;
   endfunction

   task automatic build_image(input logic [1:0] sig, input logic [15:0] seed);
      for (int i = 0; i < WORDS - 1; i++) ee[i] = 16'(i * 16'h1357) ^ seed;
      ee[10] = {sig, ee[10][13:0]};
      ee[WORDS-1] = TGT - sum_upto(WORDS - 1);
   endtask

   task automatic wait_quiet();
      int q = 0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (mem_req) q = 0; else q++;
         if (q >= 4) break;
      end
   endtask

   task automatic pulse_load();
      @(negedge clk) start_load = 1'b1;
      @(negedge clk) start_load = 1'b0;
   endtask

   task automatic do_repair();
      int w0 = n_writes;
      @(negedge clk) start_repair = 1'b1;
      @(negedge clk) start_repair = 1'b0;
      for (int i = 0; i < 1000; i++) begin
         if (n_writes != w0) break;
         @(negedge clk);
      end
      wait_quiet();
   endtask

   task automatic lookup(input logic [IW-1:0] idx, output logic [15:0] data);
      bit seen = 0;
      @(negedge clk) begin lk_req = 1'b1; lk_idx = idx; end
      @(negedge clk) lk_req = 1'b0;
      data = 'x;
      for (int i = 0; i < 3000; i++) begin
         if (lk_ack) begin data = lk_data; seen = 1; break; end
         @(negedge clk);
      end
      if (!seen) chk("lookup ack", 32'd0, 32'd1);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1 reset valid", 32'(cache_valid), 32'd0);
      chk("R1 reset err", 32'(load_err), 32'd0);
      chk("R1 reset lk_ack", 32'(lk_ack), 32'd0);
      rst_n = 1'b1;
      wait_quiet();
      chk("R1 boot read count", n_reads, 64);
      chk("R1 boot read order", order_bad, 0);
      chk("R2 good image valid", 32'(cache_valid), 32'd1);
   endtask

   task automatic t_hits();
      logic [15:0] d;
      int r0 = n_reads;
      lookup(8'd0, d);  chk("R5 hit idx0", 32'(d), 32'(ee[0]));
      lookup(8'd10, d); chk("R5 hit idx10", 32'(d), 32'(ee[10]));
      lookup(8'd63, d); chk("R5 hit idx63", 32'(d), 32'(ee[63]));
      lookup(8'd37, d); chk("R5 hit idx37", 32'(d), 32'(ee[37]));
      chk("R5 no traffic", n_reads - r0, 0);
   endtask

   task automatic t_range();
      logic [15:0] d;
      int r0 = n_reads;
      lookup(8'd64, d);  chk("R6 idx64 zero", 32'(d), 32'd0);
      lookup(8'd255, d); chk("R6 idx255 zero", 32'(d), 32'd0);
      chk("R6 no reload", n_reads - r0, 0);
   endtask

   task automatic t_repair_good();
      logic [15:0] d;
      logic [15:0] exp = TGT - sum_upto(WORDS - 1);
      int r0;
      do_repair();
      chk("R8 repair value", 32'(last_wdata), 32'(exp));
      chk("R9 invalid after write", 32'(cache_valid), 32'd0);
      r0 = n_reads;
      lookup(8'd5, d);
      chk("R7 reload on miss", n_reads - r0, 64);
      chk("R7 data after reload", 32'(d), 32'(ee[5]));
   endtask

   task automatic t_busy();
      logic [15:0] d;
      int r0 = n_reads, w0 = n_writes;
      pulse_load();
      repeat (4) @(negedge clk);
      @(negedge clk) begin start_load = 1'b1; start_repair = 1'b1; end
      @(negedge clk) begin start_load = 1'b0; start_repair = 1'b0; end
      lookup(8'd20, d);
      wait_quiet();
      chk("R11 pending lookup data", 32'(d), 32'(ee[20]));
      chk("R11 single load", n_reads - r0, 64);
      chk("R11 repair ignored", n_writes - w0, 0);
      r0 = n_reads;
      @(negedge clk) begin start_load = 1'b1; start_repair = 1'b1; end
      @(negedge clk) begin start_load = 1'b0; start_repair = 1'b0; end
      wait_quiet();
      chk("R11 load wins reads", n_reads - r0, 64);
      chk("R11 load wins writes", n_writes - w0, 0);
   endtask

   task automatic t_bad_sig();
      logic [15:0] d;
      logic [15:0] exp;
      int r0;
      build_image(2'b10, 16'h2c41);
      pulse_load();
      wait_quiet();
      chk("R4 bad signature invalid", 32'(cache_valid), 32'd0);
      r0 = n_reads;
      lookup(8'd3, d);
      chk("R7 miss reload count", n_reads - r0, 64);
      chk("R7 miss returns zero", 32'(d), 32'd0);
      exp = TGT - sum_upto(WORDS - 1);
      do_repair();
      chk("R4 word10 retained", 32'(last_wdata), 32'(exp));
   endtask

   task automatic t_bad_sum();
      logic [15:0] exp;
      build_image(2'b01, 16'h7e05);
      ee[7] = ee[7] ^ 16'h0001;
      pulse_load();
      wait_quiet();
      chk("R2 bad sum invalid", 32'(cache_valid), 32'd0);
      exp = TGT - (sum_upto(WORDS - 1) - ee[10]);
      do_repair();
      chk("R3 word10 cleared", 32'(last_wdata), 32'(exp));
      chk("R9 invalid after repair", 32'(cache_valid), 32'd0);
   endtask

   task automatic t_read_err();
      int r0;
      build_image(2'b01, 16'h0f0f);
      err_at = 20;
      r0 = n_reads;
      pulse_load();
      wait_quiet();
      chk("R10 reads stop at error", n_reads - r0, 21);
      chk("R10 invalid after error", 32'(cache_valid), 32'd0);
      chk("R10 error flag", 32'(load_err), 32'd1);
      err_at = -1;
      pulse_load();
      wait_quiet();
      chk("R10 good load valid", 32'(cache_valid), 32'd1);
      chk("R10 error sticky", 32'(load_err), 32'd1);
   endtask

   initial begin
      build_image(2'b01, 16'h0a55);
      t_reset();
      t_hits();
      t_range();
      t_repair_good();
      t_busy();
      t_bad_sig();
      t_bad_sum();
      t_read_err();
      chk("R12 request held", hold_bad, 0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #1900000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule